// File: doc/BRIEF.md
# Stereo Channel Routing Mux

This block sits between a stereo sample pair and the next stage of an audio datapath. It serves capture and playback paths alike. Each output channel picks its own source from the incoming pair. The choices are straight pass-through, a channel swap, a saturating mono sum or a mono average. Each output also has its own enable. A disabled output carries silence, which is zero.

Samples are signed two's complement values of `DATA_W` bits, 16 by default. A pair arrives with a single-cycle valid strobe. The block captures the routing controls on the same clock edge as that pair. Every registered output pair is therefore computed under exactly one set of modes. Between strobes the outputs hold their last value.

Top module: `stereo_route_mux`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0 and both output samples are 0.
- R2: `out_valid_o` is high in the cycle after each cycle with `in_valid_i` high, and low in every other cycle.
- R3: Mode code 0 (stereo): the left output takes the left input and the right output takes the right input.
- R4: Mode code 1 (swap): the left output takes the right input and the right output takes the left input.
- R5: Mode code 2 (sum): the output is left plus right, clipped to the signed range. For 16 bits that range is 0x8000 to 0x7FFF.
- R6: Mode code 3 (average): the output is (left + right) computed at full width and then shifted right arithmetically by one, so the result rounds toward minus infinity.
- R7: `route_mode_i[3:2]` selects the left output's mode and `route_mode_i[1:0]` selects the right output's mode. The two are independent. Within the control register these fields correspond to bits 11:10 and 9:8.
- R8: `route_en_i[1]` enables the left output and `route_en_i[0]` enables the right output. These correspond to register bits 15 and 14. An output whose enable is 0 produces 0.
- R9: In a cycle without `in_valid_i`, changes on the sample or control inputs leave both outputs unchanged.
- R10: Back-to-back pairs are each routed with the controls present on their own strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| route_en_i | input | 2 | Output enables: bit 1 left, bit 0 right |
| route_mode_i | input | 4 | Mode codes: [3:2] left, [1:0] right |
| in_valid_i | input | 1 | Input pair strobe |
| in_left_i | input | DATA_W | Left input sample, signed |
| in_right_i | input | DATA_W | Right input sample, signed |
| out_valid_o | output | 1 | Output pair strobe |
| out_left_o | output | DATA_W | Left output sample, signed |
| out_right_o | output | DATA_W | Right output sample, signed |

## Verification
Every routed result and its strobe appear exactly one clock after the input strobe. There is one register stage and nothing in front of it. The bench drives inputs on the falling edge. It reads the outputs on the next falling edge, half a cycle after the capturing rising edge. One cycle later it confirms that the strobe has dropped. The hold and back-to-back checks use the same one-cycle offset. In the back-to-back case, each pair's result is read on the falling edge right after its own strobe edge, before the next pair's result replaces it.

// File: rtl/stereo_route_pkg.sv
package stereo_route_pkg;
  typedef enum logic [1:0] {
    RT_STEREO = 2'd0,
    RT_SWAP   = 2'd1,
    RT_SUM    = 2'd2,
    RT_AVG    = 2'd3
  } route_mode_e;

  localparam int unsigned N_CH = 2;
  localparam int unsigned CH_L = 1;
  localparam int unsigned CH_R = 0;
endpackage

// File: rtl/mono_combine.sv
module mono_combine #(
  parameter int unsigned DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] sum_sat_o,
  output logic signed [DATA_W-1:0] avg_o
);
  localparam int unsigned WIDE_W = DATA_W + 1;
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] wide_sum;

  always_comb begin
    wide_sum = WIDE_W'(a_i) + WIDE_W'(b_i);
    // top two bits disagree -> result left the narrow range
    if (wide_sum[WIDE_W-1] != wide_sum[WIDE_W-2])
      sum_sat_o = wide_sum[WIDE_W-1] ? MIN_V : MAX_V;
    else
      sum_sat_o = wide_sum[DATA_W-1:0];
    avg_o = wide_sum[WIDE_W-1:1];
  end
endmodule

// File: rtl/route_lane.sv
module route_lane
  import stereo_route_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  route_mode_e              mode_i,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] own_i,
  input  logic signed [DATA_W-1:0] other_i,
  input  logic signed [DATA_W-1:0] sum_sat_i,
  input  logic signed [DATA_W-1:0] avg_i,
  output logic signed [DATA_W-1:0] lane_o
);
  logic signed [DATA_W-1:0] pick;

  always_comb begin
    unique case (mode_i)
      RT_STEREO: pick = own_i;
      RT_SWAP:   pick = other_i;
      RT_SUM:    pick = sum_sat_i;
      RT_AVG:    pick = avg_i;
      default:   pick = own_i;
    endcase
    lane_o = en_i ? pick : '0;
  end
endmodule

// File: rtl/stereo_route_mux.sv
module stereo_route_mux
  import stereo_route_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        route_en_i,
  input  logic [3:0]        route_mode_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_left_i,
  input  logic [DATA_W-1:0] in_right_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_left_o,
  output logic [DATA_W-1:0] out_right_o
);
  logic signed [DATA_W-1:0] ch_in  [N_CH];
  logic signed [DATA_W-1:0] ch_sel [N_CH];
  logic signed [DATA_W-1:0] ch_q   [N_CH];
  logic signed [DATA_W-1:0] sum_sat, avg;

  assign ch_in[CH_L] = in_left_i;
  assign ch_in[CH_R] = in_right_i;

  mono_combine #(.DATA_W(DATA_W)) u_mono (
    .a_i      (ch_in[CH_L]),
    .b_i      (ch_in[CH_R]),
    .sum_sat_o(sum_sat),
    .avg_o    (avg)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_lane
    route_lane #(.DATA_W(DATA_W)) u_lane (
      .mode_i   (route_mode_e'(route_mode_i[2*g+1 -: 2])),
      .en_i     (route_en_i[g]),
      .own_i    (ch_in[g]),
      .other_i  (ch_in[N_CH-1-g]),
      .sum_sat_i(sum_sat),
      .avg_i    (avg),
      .lane_o   (ch_sel[g])
    );

    // controls and samples captured on the same strobe edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         ch_q[g] <= '0;
      else if (in_valid_i) ch_q[g] <= ch_sel[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= in_valid_i;
  end

  assign out_left_o  = ch_q[CH_L];
  assign out_right_o = ch_q[CH_R];
endmodule

// File: rtl/stereo_route_chk.sv
module stereo_route_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        route_en_i,
  input logic [3:0]        route_mode_i,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_left_i,
  input logic [DATA_W-1:0] in_right_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_left_o,
  input logic [DATA_W-1:0] out_right_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R2
  AST_VALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R2
  AST_PASS_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && route_en_i[1] && route_mode_i[3:2] == 2'd0
    |=> out_left_o == $past(in_left_i)); // R3
  AST_SWAP_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && route_en_i[0] && route_mode_i[1:0] == 2'd1
    |=> out_right_o == $past(in_left_i)); // R4
  AST_SUM_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && route_en_i[0] && route_mode_i[1:0] == 2'd2
    && !in_left_i[DATA_W-1] && !in_right_i[DATA_W-1]
    |=> !out_right_o[DATA_W-1]); // R5
  AST_MUTE_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !route_en_i[1] |=> out_left_o == '0); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_left_o) && $stable(out_right_o)); // R9
endmodule

bind stereo_route_mux stereo_route_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_stereo_route_mux.sv
module tb_stereo_route_mux;
  localparam int W  = 16;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   en = '0;
  logic [3:0]   mode = '0;
  logic         vld = 1'b0;
  logic [W-1:0] l_in = '0, r_in = '0;
  logic         o_vld;
  logic [W-1:0] o_l, o_r;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  stereo_route_mux #(.DATA_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .route_en_i(en), .route_mode_i(mode),
    .in_valid_i(vld), .in_left_i(l_in), .in_right_i(r_in),
    .out_valid_o(o_vld), .out_left_o(o_l), .out_right_o(o_r)
  );

  // {en, mode, left, right, exp_left, exp_right}
  localparam logic [69:0] VEC [NV] = '{
    {2'b11, 4'b0000, 16'h1234, 16'hABCD, 16'h1234, 16'hABCD}, // R3
    {2'b11, 4'b0101, 16'h1111, 16'h2222, 16'h2222, 16'h1111}, // R4
    {2'b11, 4'b1010, 16'h0100, 16'h0200, 16'h0300, 16'h0300}, // R5
    {2'b11, 4'b1010, 16'h7000, 16'h2000, 16'h7FFF, 16'h7FFF}, // R5 clip high
    {2'b11, 4'b1010, 16'h8000, 16'hFFFF, 16'h8000, 16'h8000}, // R5 clip low
    {2'b11, 4'b1111, 16'h0003, 16'h0004, 16'h0003, 16'h0003}, // R6
    {2'b11, 4'b1111, 16'hFFFF, 16'hFFFE, 16'hFFFE, 16'hFFFE}, // R6 floor
    {2'b11, 4'b1111, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF}, // R6
    {2'b11, 4'b0110, 16'h0005, 16'h0009, 16'h0009, 16'h000E}, // R7
    {2'b11, 4'b1001, 16'h0010, 16'h0020, 16'h0030, 16'h0010}, // R7
    {2'b10, 4'b0000, 16'hAAAA, 16'h5555, 16'hAAAA, 16'h0000}, // R8
    {2'b01, 4'b0011, 16'h0002, 16'h0004, 16'h0000, 16'h0003}, // R8
    {2'b00, 4'b0000, 16'h7777, 16'h8888, 16'h0000, 16'h0000}  // R8
  };
  localparam int VREQ [NV] = '{3, 4, 5, 5, 5, 6, 6, 6, 7, 7, 8, 8, 8};

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] e, input logic [3:0] m,
                      input logic [W-1:0] l, input logic [W-1:0] r);
    en = e; mode = m; l_in = l; r_in = r; vld = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", {15'd0, o_vld}, 16'd0);
    check("R1 left", o_l, 16'd0);
    check("R1 right", o_r, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][69:68], VEC[i][67:64], VEC[i][63:48], VEC[i][47:32]);
      @(negedge clk);
      vld = 1'b0;
      check($sformatf("R%0d vec%0d valid", VREQ[i], i), {15'd0, o_vld}, 16'd1);
      check($sformatf("R%0d vec%0d left", VREQ[i], i), o_l, VEC[i][31:16]);
      check($sformatf("R%0d vec%0d right", VREQ[i], i), o_r, VEC[i][15:0]);
      @(negedge clk);
      check("R2 strobe drops", {15'd0, o_vld}, 16'd0);
    end

    // R9: load a known pair, then disturb inputs without a strobe
    send(2'b11, 4'b0000, 16'h0A0A, 16'h0B0B);
    @(negedge clk);
    vld = 1'b0;
    en = 2'b00; mode = 4'b1111; l_in = 16'h7FFF; r_in = 16'h8000;
    repeat (3) @(negedge clk);
    check("R9 hold left", o_l, 16'h0A0A);
    check("R9 hold right", o_r, 16'h0B0B);
    check("R9 no strobe", {15'd0, o_vld}, 16'd0);

    // R10: back-to-back pairs under different modes
    send(2'b11, 4'b0000, 16'h0001, 16'h0002);
    @(negedge clk);
    send(2'b11, 4'b0101, 16'h0003, 16'h0004);
    check("R10 first left", o_l, 16'h0001);
    check("R10 first right", o_r, 16'h0002);
    @(negedge clk);
    vld = 1'b0;
    check("R10 second valid", {15'd0, o_vld}, 16'd1);
    check("R10 second left", o_l, 16'h0004);
    check("R10 second right", o_r, 16'h0003);
    @(negedge clk);

    // R1: reset in mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R1 re-reset left", o_l, 16'd0);
    check("R1 re-reset right", o_r, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule